// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a bank of independent 32-bit timer channels on a simple register bus. Software programs each channel with a start count, a run mode and an interrupt mask, then enables it. While enabled, the live count drops by one on every clock. When the count is zero, the channel raises its pending flag. In periodic mode the counter then refills from the stored start count. In one-shot mode it parks at zero and switches itself off.

Each channel drives its own interrupt line, which is its pending flag gated by its mask. Clearing a pending flag takes a short, fixed number of cycles, and a busy bit shows that a clear is in progress. A shared summary word collects the pending flags of all channels. One slot in both the address space and the summary word is reserved and never used by a channel. Writes take effect on the rising clock edge where `bus_sel`, `bus_enable` and `bus_write` are all high. Read data is combinational from the address and is zero when `bus_sel` is low.

Top module: `tmr_bank`

## Requirements
- R1: Each channel owns a 64-byte register block. Channels 0 to 3 sit in blocks 0 to 3, and channels 4 to 6 sit in blocks 5 to 7. Block 4 is reserved: it reads 0 (apart from the summary offset) and ignores writes. Offsets within a block are: 0x04 mode (bit 0), 0x08 start count, 0x10 run enable (bit 0), 0x14 refill strobe (reads 0), 0x18 live count, 0x20 clear/status, 0x24 mask (bit 0). Every other offset reads 0.
- R2: After reset, every register reads 0 except the mask bit, which reads 1, and every interrupt line is low.
- R3: An enabled channel's live count drops by exactly one per clock while it is above zero. A disabled channel's count holds.
- R4: An enabled channel whose count is 0 sets its pending flag at that edge. In periodic mode (mode bit 0) it refills from the start count, so it fires every start+1 cycles.
- R5: In one-shot mode (mode bit 1), after the zero event the count stays 0 and the enable bit reads 0.
- R6: A write of any data to the refill offset copies the start count into the live count at that edge, and the channel does not count on that edge.
- R7: Writing enable bit 1 to a stopped channel copies the start count into the live count. Writing 0 stops the channel and leaves the count unchanged.
- R8: In the clear/status register, bit 0 reads the pending flag and bit 1 reads busy. Writing 1 to bit 0 makes busy read 1 for the next 2 cycles, after which the flag drops. Writing 0 to bit 0 has no effect.
- R9: A clear write made while busy reads 1 is ignored and does not extend the busy window.
- R10: If a zero event occurs on any edge from the accepted clear write through the final edge of the busy window, the pending flag remains set.
- R11: A channel's interrupt line is high exactly when its pending flag is 1 and its mask bit is 0.
- R12: The summary word at offset 0x00 of any block is laid out as follows: bits 0 to 3 are the flags of channels 0 to 3, bit 4 reads 0, bits 5 to 7 are the flags of channels 4 to 6, and bits 8 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Selects the block for a transfer |
| bus_enable | input | 1 | Access phase of a transfer |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| irq | output | NCH (7) | Per-channel masked interrupt lines |

## Verification
A write becomes visible one edge after the cycle in which it is presented. A read returns the current state in the same cycle. The pending flag and the interrupt line follow a zero event by one edge. A clear drops the flag on the second edge after the edge that accepted it. The bench drives every input on the falling edge and advances a behavioural model on each rising edge. It compares the interrupt vector with the model at every falling edge, and it compares register reads one time unit after it sets the address. Every sample therefore falls between the edges that produce it and the edges that could change it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW       = 32;
  localparam int OFF_W    = 6;
  localparam int WDT_SLOT = 4;

  localparam logic [OFF_W-1:0] OFF_SUM  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_MODE = 6'h04;
  localparam logic [OFF_W-1:0] OFF_LOAD = 6'h08;
  localparam logic [OFF_W-1:0] OFF_ENA  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_RLD  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_CNT  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_CLR  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_MSK  = 6'h24;

  typedef struct packed {
    logic          mode;
    logic          ena;
    logic          mask;
    logic          stat;
    logic          busy;
    logic [DW-1:0] cnt;
    logic [DW-1:0] load;
  } chan_view_t;

  // address block (and summary bit) occupied by a channel
  function automatic int slot_of(input int ch);
    return (ch < WDT_SLOT) ? ch : ch + 1;
  endfunction

  function automatic logic [DW-1:0] count_step(input logic [DW-1:0] c);
    return c - DW'(1);
  endfunction

  function automatic logic [DW-1:0] clr_word(input logic busy, input logic stat);
    return {{(DW-2){1'b0}}, busy, stat};
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int CLR_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          we_mode,
  input  logic          we_load,
  input  logic          we_ena,
  input  logic          we_rld,
  input  logic          we_clr,
  input  logic          we_mask,
  output chan_view_t    view,
  output logic          irq,
  output logic          zero_evt,
  output logic          clr_accept,
  output logic          clr_done
);
  localparam int BW = $clog2(CLR_CYC + 1);

  logic          mode_q, ena_q, mask_q, stat_q, seen_q;
  logic [DW-1:0] load_q, cnt_q;
  logic [BW-1:0] bcnt_q;
  logic [DW-1:0] cnt_d;
  logic          ena_d, stat_d, seen_d;
  logic          tick, start, busy;

  assign tick       = ena_q && !we_rld && !we_ena;
  assign start      = we_ena && wdata[0] && !ena_q;
  assign zero_evt   = tick && (cnt_q == '0);
  assign busy       = (bcnt_q != '0);
  assign clr_accept = we_clr && wdata[0] && !busy;
  assign clr_done   = (bcnt_q == BW'(1));

  always_comb begin
    cnt_d = cnt_q;
    ena_d = ena_q;
    if (we_rld || start)
      cnt_d = load_q;
    else if (tick)
      cnt_d = (cnt_q == '0) ? (mode_q ? '0 : load_q) : count_step(cnt_q);
    if (we_ena)
      ena_d = wdata[0];
    else if (zero_evt && mode_q)
      ena_d = 1'b0;
  end

  always_comb begin
    stat_d = zero_evt | (stat_q & ~(clr_done & ~seen_q));
    if (clr_accept)  seen_d = zero_evt;
    else if (busy)   seen_d = seen_q | zero_evt;
    else             seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ena_q  <= 1'b0;
      mask_q <= 1'b1;
      stat_q <= 1'b0;
      seen_q <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (we_mode) mode_q <= wdata[0];
      if (we_mask) mask_q <= wdata[0];
      if (we_load) load_q <= wdata;
      ena_q  <= ena_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      seen_q <= seen_d;
      if (clr_accept)  bcnt_q <= BW'(CLR_CYC);
      else if (busy)   bcnt_q <= bcnt_q - BW'(1);
    end
  end

  assign irq  = stat_q & ~mask_q;
  assign view = '{mode: mode_q, ena: ena_q, mask: mask_q, stat: stat_q,
                  busy: busy, cnt: cnt_q, load: load_q};
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif import tmr_pkg::*; #(
  parameter int NCH    = 7,
  parameter int ADDR_W = 9
) (
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  chan_view_t        views [NCH],
  output logic [NCH-1:0]    we_mode,
  output logic [NCH-1:0]    we_load,
  output logic [NCH-1:0]    we_ena,
  output logic [NCH-1:0]    we_rld,
  output logic [NCH-1:0]    we_clr,
  output logic [NCH-1:0]    we_mask,
  output logic [NCH-1:0]    wr_hit,
  output logic [DW-1:0]     bus_rdata
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0] blk;
  logic [OFF_W-1:0] off;
  logic             wr;
  logic [DW-1:0]    summary;
  logic [DW-1:0]    rd_mux;

  assign blk = bus_addr[ADDR_W-1:OFF_W];
  assign off = bus_addr[OFF_W-1:0];
  assign wr  = bus_sel && bus_enable && bus_write;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [BLK_W-1:0] SLOT = BLK_W'(slot_of(i));
    assign wr_hit[i]  = wr && (blk == SLOT);
    assign we_mode[i] = wr_hit[i] && (off == OFF_MODE);
    assign we_load[i] = wr_hit[i] && (off == OFF_LOAD);
    assign we_ena[i]  = wr_hit[i] && (off == OFF_ENA);
    assign we_rld[i]  = wr_hit[i] && (off == OFF_RLD);
    assign we_clr[i]  = wr_hit[i] && (off == OFF_CLR);
    assign we_mask[i] = wr_hit[i] && (off == OFF_MSK);
  end

  always_comb begin
    summary = '0;
    for (int i = 0; i < NCH; i++)
      summary[slot_of(i)] = views[i].stat;
  end

  always_comb begin
    rd_mux = '0;
    if (off == OFF_SUM) begin
      rd_mux = summary;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (blk == BLK_W'(slot_of(i))) begin
          case (off)
            OFF_MODE: rd_mux = DW'(views[i].mode);
            OFF_LOAD: rd_mux = views[i].load;
            OFF_ENA:  rd_mux = DW'(views[i].ena);
            OFF_CNT:  rd_mux = views[i].cnt;
            OFF_CLR:  rd_mux = clr_word(views[i].busy, views[i].stat);
            OFF_MSK:  rd_mux = DW'(views[i].mask);
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = bus_sel ? rd_mux : '0;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_pkg::*; #(
  parameter int NCH     = 7,
  parameter int CLR_CYC = 2,
  parameter int ADDR_W  = $clog2((NCH + 1) * (1 << OFF_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  chan_view_t     views [NCH];
  logic [NCH-1:0] we_mode, we_load, we_ena, we_rld, we_clr, we_mask, wr_hit;
  logic [NCH-1:0] zero_evt, clr_accept, clr_done;
  logic [NCH-1:0] stat_v, ena_v, mode_v, mask_v, busy_v;
  logic [DW-1:0]  cnt_a  [NCH];
  logic [DW-1:0]  load_a [NCH];

  tmr_regif #(.NCH(NCH), .ADDR_W(ADDR_W)) regif_i (
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .views(views),
    .we_mode(we_mode), .we_load(we_load), .we_ena(we_ena), .we_rld(we_rld),
    .we_clr(we_clr), .we_mask(we_mask), .wr_hit(wr_hit), .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan #(.CLR_CYC(CLR_CYC)) chan_i (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
      .we_mode(we_mode[i]), .we_load(we_load[i]), .we_ena(we_ena[i]),
      .we_rld(we_rld[i]), .we_clr(we_clr[i]), .we_mask(we_mask[i]),
      .view(views[i]), .irq(irq[i]), .zero_evt(zero_evt[i]),
      .clr_accept(clr_accept[i]), .clr_done(clr_done[i])
    );
    assign stat_v[i] = views[i].stat;
    assign ena_v[i]  = views[i].ena;
    assign mode_v[i] = views[i].mode;
    assign mask_v[i] = views[i].mask;
    assign busy_v[i] = views[i].busy;
    assign cnt_a[i]  = views[i].cnt;
    assign load_a[i] = views[i].load;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH     = 7,
  parameter int CLR_CYC = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] zero_evt,
  input logic [NCH-1:0] clr_accept,
  input logic [NCH-1:0] clr_done,
  input logic [NCH-1:0] wr_hit,
  input logic [NCH-1:0] stat_v,
  input logic [NCH-1:0] ena_v,
  input logic [NCH-1:0] mode_v,
  input logic [NCH-1:0] mask_v,
  input logic [NCH-1:0] busy_v,
  input logic [31:0]    cnt_a  [NCH],
  input logic [31:0]    load_a [NCH]
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_v[i] && !wr_hit[i] && cnt_a[i] != 32'd0) |=> (cnt_a[i] == $past(cnt_a[i]) - 32'd1));
    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena_v[i] && !wr_hit[i]) |=> $stable(cnt_a[i]));
    // R4
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] |=> stat_v[i]);
    // R4
    periodic_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt[i] && !mode_v[i] && !wr_hit[i]) |=> (cnt_a[i] == load_a[i]));
    // R5
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt[i] && mode_v[i] && !wr_hit[i]) |=> (!ena_v[i] && cnt_a[i] == 32'd0));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_accept[i] |=> busy_v[i]);
    // R8
    stat_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_v[i] && !clr_done[i] && stat_v[i]) |=> stat_v[i]);
    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_v[i] |-> !clr_accept[i]);
    // R11
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_v[i] |-> !irq[i]);
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CLR_CYC(CLR_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .zero_evt(zero_evt),
  .clr_accept(clr_accept), .clr_done(clr_done), .wr_hit(wr_hit),
  .stat_v(stat_v), .ena_v(ena_v), .mode_v(mode_v), .mask_v(mask_v),
  .busy_v(busy_v), .cnt_a(cnt_a), .load_a(load_a)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 7;
  localparam int CLR        = 2;
  localparam int MAX_CYC    = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  tmr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int unsigned m_cnt [NCH], m_load [NCH];
  bit          m_mode [NCH], m_ena [NCH], m_mask [NCH], m_stat [NCH], m_seen [NCH];
  int          m_end [NCH];
  int          n;

  function automatic int slot(input int ch);
    return ch < 4 ? ch : ch + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0;
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 0; m_load[i] = 0; m_mode[i] = 0; m_ena[i] = 0;
        m_mask[i] = 1; m_stat[i] = 0; m_seen[i] = 0; m_end[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit hit, busy, last, tick, ev, acc, nstat;
        int off;
        int unsigned d;
        hit  = bus_sel && bus_enable && bus_write && (int'(bus_addr) / 64 == slot(i));
        off  = int'(bus_addr) % 64;
        d    = bus_wdata;
        busy = n < m_end[i];
        last = (n == m_end[i] - 1);
        tick = m_ena[i] && !(hit && (off == 20 || off == 16));
        ev   = tick && m_cnt[i] == 0;
        acc  = hit && off == 32 && d[0] && !busy;
        if (hit && off == 20)                        m_cnt[i] = m_load[i];
        else if (hit && off == 16 && d[0] && !m_ena[i]) m_cnt[i] = m_load[i];
        else if (tick) m_cnt[i] = (m_cnt[i] == 0) ? (m_mode[i] ? 0 : m_load[i]) : m_cnt[i] - 1;
        if (hit && off == 16)      m_ena[i] = d[0];
        else if (ev && m_mode[i])  m_ena[i] = 0;
        if (hit && off == 8)  m_load[i] = d;
        if (hit && off == 4)  m_mode[i] = d[0];
        if (hit && off == 36) m_mask[i] = d[0];
        nstat = ev ? 1'b1 : ((last && !m_seen[i]) ? 1'b0 : m_stat[i]);
        if (acc) begin m_seen[i] = ev; m_end[i] = n + 1 + CLR; end
        else if (busy) m_seen[i] = m_seen[i] | ev;
        else m_seen[i] = 0;
        m_stat[i] = nstat;
      end
      n++;
    end
  end

  function automatic int unsigned model_rd(input int a);
    int off, sl;
    int unsigned r;
    off = a % 64; sl = a / 64; r = 0;
    if (off == 0) begin
      for (int i = 0; i < NCH; i++) if (m_stat[i]) r |= (32'd1 << slot(i));
      return r;
    end
    for (int i = 0; i < NCH; i++) begin
      if (slot(i) == sl) begin
        case (off)
          4:  r = m_mode[i];
          8:  r = m_load[i];
          16: r = m_ena[i];
          24: r = m_cnt[i];
          32: r = ((n < m_end[i]) ? 2 : 0) | (m_stat[i] ? 1 : 0);
          36: r = m_mask[i];
          default: r = 0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R11: interrupt vector against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int unsigned e;
      e = 0;
      for (int i = 0; i < NCH; i++) if (m_stat[i] && !m_mask[i]) e |= (32'd1 << i);
      chk("R11 irq vector", irq, e);
    end
  end

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    bus_sel = 1; bus_enable = 1; bus_write = 1; bus_addr = a[8:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_enable = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, input string tag);
    bus_sel = 1; bus_enable = 1; bus_write = 0; bus_addr = a[8:0];
    #1;
    chk(tag, bus_rdata, model_rd(a));
    bus_sel = 0; bus_enable = 0;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wrap_up;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", MAX_CYC, MAX_CYC);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    rd(12'h004, "R2 mode reset");
    rd(12'h024, "R2 mask reset");
    rd(12'h1E4, "R2 ch6 mask reset");
    rd(12'h018, "R2 count reset");
    rd(12'h020, "R2 clear reg reset");
    rd(12'h000, "R12 summary reset");
    // R1 map and reserved block
    wr(12'h148, 32'h1234);
    rd(12'h148, "R1 ch4 load in block 5");
    wr(12'h108, 32'hBEEF);
    rd(12'h108, "R1 reserved block load");
    rd(12'h10C, "R1 unused offset");
    rd(12'h014, "R1 refill reads zero");
    // R3 R4 periodic channel 0
    wr(12'h008, 4); wr(12'h024, 0); wr(12'h010, 1);
    for (int k = 0; k < 12; k++) begin rd(12'h018, "R3 R4 periodic count"); rd(12'h020, "R4 flag"); step(1); end
    // R7 stop holds count
    wr(12'h010, 0);
    rd(12'h018, "R7 stop holds"); step(3); rd(12'h018, "R3 idle holds");
    // R8 clear with busy window, R9 second write ignored
    wr(12'h020, 1);
    rd(12'h020, "R8 busy after clear");
    wr(12'h020, 1);
    rd(12'h020, "R9 busy not extended");
    step(1);
    rd(12'h020, "R8 flag dropped");
    // R8 writing 0 does nothing
    wr(12'h010, 1); step(6); wr(12'h010, 0);
    rd(12'h020, "R8 flag set again");
    wr(12'h020, 0);
    rd(12'h020, "R8 zero write no effect");
    // R5 one-shot on channel 1
    wr(12'h044, 1); wr(12'h048, 3); wr(12'h064, 0); wr(12'h050, 1);
    for (int k = 0; k < 7; k++) begin rd(12'h058, "R5 oneshot count"); rd(12'h050, "R5 oneshot enable"); step(1); end
    // R7 restart from start count
    wr(12'h050, 1);
    rd(12'h058, "R7 restart loads");
    step(2);
    rd(12'h058, "R7 restart counting");
    // R11 mask hides the line
    wr(12'h064, 1); step(2); rd(12'h000, "R12 summary with masked ch1");
    // R6 refill strobe on channel 2
    wr(12'h088, 100); wr(12'h090, 1); step(5);
    rd(12'h098, "R6 before refill");
    wr(12'h094, 0);
    rd(12'h098, "R6 after refill");
    // R12 summary positions for channels 4 and 6
    wr(12'h144, 1); wr(12'h148, 2); wr(12'h150, 1);
    wr(12'h1C4, 1); wr(12'h1C8, 1); wr(12'h1E4, 0); wr(12'h1D0, 1);
    step(5);
    rd(12'h000, "R12 summary ch4 ch6");
    rd(12'h100, "R12 summary from reserved block");
    // R10 event inside clear window (channel 3 fires every cycle)
    wr(12'h0E4, 0); wr(12'h0C8, 0); wr(12'h0D0, 1);
    step(2);
    wr(12'h0E0, 1);
    rd(12'h0E0, "R10 busy with events");
    step(3);
    rd(12'h0E0, "R10 flag survives");
    // R10 periodic period 2 with clear
    wr(12'h0D0, 0); wr(12'h0C8, 1); wr(12'h0D0, 1); step(3);
    wr(12'h0E0, 1); step(3);
    rd(12'h0E0, "R10 period two clear");
    step(4);
    wrap_up();
  end
endmodule